// File: doc/BRIEF.md
# Page-Offset-Indexed Instruction Cache with Wrapping Burst Refill

This block is a small direct-mapped instruction cache that serves a processor's fetch port. It holds 256 bytes as 16 lines, and each line is four 32-bit words on a 16-byte boundary. The array is addressed only with bits that lie inside the 4 KiB page offset, so the read can begin before address translation finishes. A translation unit outside the block supplies the physical page number in the same cycle. Each line stores a physical page number as its tag, and that tag is compared with the translated number to decide whether the access hits.

On a miss, the block requests one line from memory. Memory answers with four beats that start at the missed word and wrap around within the line. The first beat is passed straight to the fetch port. The line becomes usable only after all four words are written. A single input discards every line at once and abandons any refill in progress.

Top module: `pgoff_icache`

## Requirements
- R1: When `fetch_req` and `xlat_valid` are both high, `fetch_hit` is high in the same cycle exactly when the indexed line is valid and its stored page number equals `xlat_ppn`. `fetch_data` then carries the word chosen by `fetch_woff[1:0]`.
- R2: The line index is `fetch_woff[5:2]`, which is byte-address bits [7:4]. Byte-address bits [11:8], which are `fetch_woff[9:6]`, do not take part in selecting the line or in the hit decision.
- R3: A lookup with `xlat_valid` high that misses while no refill is running raises `mem_req` from the next cycle. `mem_addr` is then `{xlat_ppn, fetch_woff, 2'b00}`, the byte address of the missed word.
- R4: Refill beat k (k = 0..3) is written into word (w + k) mod 4 of the line, where w is `fetch_woff[1:0]` of the miss.
- R5: In the cycle the first beat arrives (`mem_rvalid` while `mem_req` is high), `fetch_fwd` is high and `fetch_data` equals `mem_rdata`.
- R6: A line being refilled reports a miss for any lookup until its fourth beat has been written.
- R7: A lookup with `xlat_valid` low never hits and never starts a refill.
- R8: When `flush_all` is high at a clock edge, every line is invalid from the next cycle on. A refill in progress is dropped: `mem_req` is low in the next cycle, and the partly written line stays invalid.
- R9: `mem_req` stays high, with a stable `mem_addr`, from the start of a refill until the first beat arrives. It is low for the remaining beats.
- R10: While a refill is running, lookups to other valid lines still hit, and further misses start no second refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch lookup this cycle |
| fetch_woff | input | 10 | Word address within the page (byte-address bits [11:2]) |
| xlat_valid | input | 1 | Translation result valid |
| xlat_ppn | input | 20 | Translated physical page number |
| fetch_hit | output | 1 | Lookup hit in the array |
| fetch_fwd | output | 1 | Missed word forwarded from the first refill beat |
| fetch_data | output | 32 | Fetched instruction word |
| mem_req | output | 1 | Line refill request, held until the first beat |
| mem_addr | output | 32 | Physical byte address of the missed word |
| mem_rvalid | input | 1 | Refill beat valid |
| mem_rdata | input | 32 | Refill beat data |
| flush_all | input | 1 | Invalidate all lines and abandon refill |

## Verification
The hardest condition to reach from the ports is a flush that lands partway through a refill, after some beats have been written but before the line is marked valid. The stimulus starts a refill, returns exactly two beats, and raises `flush_all` in the gap. It then looks up the half-filled line and the previously valid lines. Each of those lookups must miss and start a new refill, and every such refill is driven to completion. A second hard case is a hit under an outstanding refill. To reach it, the bench opens a refill on one index and looks up a different, already valid index before the beats arrive.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [1:0] {
      FILL_IDLE = 2'd0,
      FILL_WAIT = 2'd1,
      FILL_BEAT = 2'd2
   } fill_state_e;
endpackage

// File: rtl/pic_tag_store.sv
module pic_tag_store #(
   parameter int LINES = 16,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             alloc_en,
   input  logic [IDX_W-1:0] alloc_idx,
   input  logic [TAG_W-1:0] alloc_tag,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             flush
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
            tag_q[i]   <= '0;
         end else begin
            if (flush)
               valid_q[i] <= 1'b0;
            else if (alloc_en && alloc_idx == IDX_W'(i))
               valid_q[i] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))
               valid_q[i] <= 1'b1;
            if (alloc_en && alloc_idx == IDX_W'(i))
               tag_q[i] <= alloc_tag;
         end
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   AST_FLUSH_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0)); // R8
   AST_ALLOC_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> !valid_q[$past(alloc_idx)]); // R6
endmodule

// File: rtl/pic_data_store.sv
module pic_data_store #(
   parameter int LINES  = 16,
   parameter int WORDS  = 4,
   parameter int WORD_W = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_word,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem_q [LINES][WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_idx][wr_word] <= wr_data;
   end

   assign rd_data = mem_q[rd_idx][rd_word];
endmodule

// File: rtl/pic_fill_ctrl.sv
module pic_fill_ctrl
   import pic_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int WORDS  = 4,
   parameter int ADDR_W = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WSEL_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic [WSEL_W-1:0] start_word,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              mem_rvalid,
   input  logic              flush,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              beat_wr,
   output logic [IDX_W-1:0]  fill_idx,
   output logic [WSEL_W-1:0] fill_word,
   output logic              fill_done,
   output logic              first_beat
);
   fill_state_e       st_q;
   logic [WSEL_W-1:0] cnt_q;
   logic [WSEL_W-1:0] w0_q;

   assign busy       = (st_q != FILL_IDLE);
   assign mem_req    = (st_q == FILL_WAIT);
   assign beat_wr    = busy && mem_rvalid && !flush;
   assign first_beat = mem_req && mem_rvalid && !flush;
   assign fill_word  = w0_q + cnt_q;
   assign fill_done  = beat_wr && (cnt_q == WSEL_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= FILL_IDLE;
         cnt_q    <= '0;
         w0_q     <= '0;
         fill_idx <= '0;
         mem_addr <= '0;
      end else if (flush) begin
         st_q <= FILL_IDLE;
      end else begin
         unique case (st_q)
            FILL_IDLE: if (start) begin
               st_q     <= FILL_WAIT;
               cnt_q    <= '0;
               w0_q     <= start_word;
               fill_idx <= start_idx;
               mem_addr <= start_addr;
            end
            FILL_WAIT: if (mem_rvalid) begin
               st_q  <= FILL_BEAT;
               cnt_q <= cnt_q + 1'b1;
            end
            FILL_BEAT: if (mem_rvalid) begin
               cnt_q <= cnt_q + 1'b1;
               if (fill_done) st_q <= FILL_IDLE;
            end
            default: st_q <= FILL_IDLE;
         endcase
      end
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid && !flush) |=> mem_req); // R9
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> $stable(mem_addr)); // R9
   AST_FLUSH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !busy); // R8
   AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fill_done && !flush) |=> $stable(fill_idx)); // R10
endmodule

// File: rtl/pgoff_icache.sv
module pgoff_icache #(
   parameter int LINES     = 16,
   parameter int WORDS     = 4,
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter bit CRIT_FWD  = 1'b1,
   localparam int IDX_W   = $clog2(LINES),
   localparam int WSEL_W  = $clog2(WORDS),
   localparam int BYTE_W  = $clog2(WORD_W / 8),
   localparam int WOFF_W  = PAGE_BITS - BYTE_W,
   localparam int TAG_W   = ADDR_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [WOFF_W-1:0] fetch_woff,
   input  logic              xlat_valid,
   input  logic [TAG_W-1:0]  xlat_ppn,
   output logic              fetch_hit,
   output logic              fetch_fwd,
   output logic [WORD_W-1:0] fetch_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              flush_all
);
   if (WSEL_W + IDX_W > WOFF_W) begin : g_bad_geom
      $error("index and word bits must fit inside the page offset");
   end
   if ((1 << WSEL_W) != WORDS || (1 << IDX_W) != LINES) begin : g_bad_pow2
      $error("LINES and WORDS must be powers of two");
   end

   logic [IDX_W-1:0]  lk_idx;
   logic [WSEL_W-1:0] lk_word;
   logic              lk_valid, lk_hit, miss_start, busy;
   logic [TAG_W-1:0]  lk_tag;
   logic [WORD_W-1:0] arr_data;
   logic              beat_wr, fill_done, first_beat;
   logic [IDX_W-1:0]  fill_idx;
   logic [WSEL_W-1:0] fill_word;

   assign lk_word    = fetch_woff[WSEL_W-1:0];
   assign lk_idx     = fetch_woff[WSEL_W +: IDX_W];
   assign lk_hit     = fetch_req && xlat_valid && lk_valid && (lk_tag == xlat_ppn);
   assign miss_start = fetch_req && xlat_valid && !lk_hit && !busy && !flush_all;
   assign fetch_hit  = lk_hit;

   pic_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_valid(lk_valid), .rd_tag(lk_tag),
      .alloc_en(miss_start), .alloc_idx(lk_idx), .alloc_tag(xlat_ppn),
      .set_en(fill_done), .set_idx(fill_idx), .flush(flush_all)
   );

   pic_data_store #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
      .clk(clk), .wr_en(beat_wr), .wr_idx(fill_idx), .wr_word(fill_word),
      .wr_data(mem_rdata), .rd_idx(lk_idx), .rd_word(lk_word), .rd_data(arr_data)
   );

   pic_fill_ctrl #(.LINES(LINES), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .start(miss_start), .start_idx(lk_idx),
      .start_word(lk_word),
      .start_addr({xlat_ppn, fetch_woff, {BYTE_W{1'b0}}}),
      .mem_rvalid(mem_rvalid), .flush(flush_all), .busy(busy),
      .mem_req(mem_req), .mem_addr(mem_addr), .beat_wr(beat_wr),
      .fill_idx(fill_idx), .fill_word(fill_word), .fill_done(fill_done),
      .first_beat(first_beat)
   );

   if (CRIT_FWD) begin : g_fwd
      assign fetch_fwd  = first_beat;
      assign fetch_data = first_beat ? mem_rdata : arr_data;
   end else begin : g_nofwd
      assign fetch_fwd  = 1'b0;
      assign fetch_data = arr_data;
      logic unused_fb;
      assign unused_fb = first_beat;
   end

   AST_FILLING_LINE_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fetch_req && lk_idx == fill_idx) |-> !fetch_hit); // R6
   AST_FILL_NEEDS_XLAT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(xlat_valid)); // R7
   AST_FWD_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_fwd |-> (mem_rvalid && mem_req)); // R5
endmodule

// File: tb/pgoff_icache_test.sv
module pgoff_icache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [9:0]  fetch_woff = '0;
   logic        xlat_valid = 1'b0;
   logic [19:0] xlat_ppn = '0;
   logic        fetch_hit, fetch_fwd, mem_req;
   logic [31:0] fetch_data, mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        flush_all = 1'b0;

   int vectors = 0;
   int fails = 0;

   always #4 clk = ~clk;

   pgoff_icache uut (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_woff(fetch_woff),
      .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn), .fetch_hit(fetch_hit),
      .fetch_fwd(fetch_fwd), .fetch_data(fetch_data), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .flush_all(flush_all)
   );

   typedef struct packed {
      logic        hit;
      logic        fwd;
      logic        chk_data;
      logic [31:0] data;
      logic        req;
      logic        chk_addr;
      logic [31:0] addr;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];

   localparam logic [19:0] PA = 20'h12345;
   localparam logic [19:0] PB = 20'h0ABCD;

   function automatic logic [31:0] mdata(logic [19:0] p, int idx, int w);
      return {p[11:0], 4'(idx), 2'(w), 14'h01A5};
   endfunction

   function automatic logic [31:0] va_of(int idx, int w);
      return {24'h0, 4'(idx), 2'(w), 2'b00};
   endfunction

   task automatic probe(input logic rq, input logic [31:0] va, input logic xv,
                        input logic [19:0] pn, input logic rv, input logic [31:0] rd,
                        input logic fl, input logic eh, input logic ef, input logic cd,
                        input logic [31:0] ed, input logic er, input logic ca,
                        input logic [31:0] ea, input string tg);
      exp_t e;
      @(negedge clk);
      fetch_req  = rq;
      fetch_woff = va[11:2];
      xlat_valid = xv;
      xlat_ppn   = pn;
      mem_rvalid = rv;
      mem_rdata  = rd;
      flush_all  = fl;
      e = '{hit: eh, fwd: ef, chk_data: cd, data: ed, req: er, chk_addr: ca, addr: ea};
      expq.push_back(e);
      tagq.push_back(tg);
      @(posedge clk);
   endtask

   task automatic idle(input logic er, input string tg);
      probe(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, er, 0, 0, tg);
   endtask

   task automatic lookup(input logic [31:0] va, input logic [19:0] pn, input logic eh,
                         input logic [31:0] ed, input string tg);
      probe(1, va, 1, pn, 0, 0, 0, eh, 0, eh, ed, 0, 0, 0, tg);
   endtask

   // Run after the missing lookup; ova/opn is a second lookup made during the refill.
   task automatic fill(input logic [19:0] pn, input logic [31:0] va,
                       input logic [31:0] ova, input logic [19:0] opn,
                       input logic ohit, input logic [31:0] odata);
      int idx = int'(va[7:4]);
      int w   = int'(va[3:2]);
      probe(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, {pn, va[11:2], 2'b00}, "R3");
      probe(1, va, 1, pn, 0, 0, 0, 0, 0, 0, 0, 1, 1, {pn, va[11:2], 2'b00}, "R6");
      probe(1, ova, 1, opn, 0, 0, 0, ohit, 0, ohit, odata, 1, 1,
            {pn, va[11:2], 2'b00}, "R10");
      for (int k = 0; k < 4; k++) begin
         logic [31:0] d = mdata(pn, idx, (w + k) % 4);
         probe(0, 0, 0, 0, 1, d, 0, 0, (k == 0), (k == 0), d, (k == 0), 0, 0,
               (k == 0) ? "R5" : "R9");
      end
      idle(0, "R9");
   endtask

   // monitor: pops expectations and compares just before the next rising edge
   initial begin
      forever begin
         exp_t  e;
         string tg;
         bit    bad;
         wait (expq.size() > 0);
         #2;
         e  = expq.pop_front();
         tg = tagq.pop_front();
         bad = 0;
         vectors++;
         if (fetch_hit !== e.hit) begin
            $display("FAIL %s fetch_hit act %0b exp %0b", tg, fetch_hit, e.hit); bad = 1;
         end
         if (fetch_fwd !== e.fwd) begin
            $display("FAIL %s fetch_fwd act %0b exp %0b", tg, fetch_fwd, e.fwd); bad = 1;
         end
         if (e.chk_data && fetch_data !== e.data) begin
            $display("FAIL %s fetch_data act %h exp %h", tg, fetch_data, e.data); bad = 1;
         end
         if (mem_req !== e.req) begin
            $display("FAIL %s mem_req act %0b exp %0b", tg, mem_req, e.req); bad = 1;
         end
         if (e.chk_addr && mem_addr !== e.addr) begin
            $display("FAIL %s mem_addr act %h exp %h", tg, mem_addr, e.addr); bad = 1;
         end
         if (bad) fails++;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all R) act timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      idle(0, "R3 reset");
      // R7: no translation, no hit, no refill
      probe(1, 32'h128, 0, PA, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      idle(0, "R7");
      // R3: miss line 2 word 2 under page A, refill wraps 2,3,0,1
      lookup(32'h128, PA, 0, 0, "R3");
      fill(PA, 32'h128, 32'h128, PA, 0, 0);
      for (int w = 0; w < 4; w++) lookup(va_of(2, w), PA, 1, mdata(PA, 2, w), "R4");
      // R2: bits [11:8] differ, same line
      lookup(32'hF24, PA, 1, mdata(PA, 2, 1), "R2");
      lookup(32'h724, PA, 1, mdata(PA, 2, 1), "R2");
      // R1: tag mismatch misses, then line is replaced for page B
      lookup(32'h128, PB, 0, 0, "R1");
      fill(PB, 32'h128, 32'h128, PB, 0, 0);
      lookup(va_of(2, 0), PB, 1, mdata(PB, 2, 0), "R1");
      // R10: refill line 5 word 3 while line 2 (page B) keeps hitting
      lookup(32'h05C, PA, 0, 0, "R10");
      fill(PA, 32'h05C, va_of(2, 3), PB, 1, mdata(PB, 2, 3));
      for (int w = 0; w < 4; w++) lookup(va_of(5, w), PA, 1, mdata(PA, 5, w), "R4");
      // R8: flush in the middle of a refill of line 9
      lookup(32'h090, PA, 0, 0, "R8");
      idle(1, "R9");
      probe(0, 0, 0, 0, 1, mdata(PA, 9, 0), 0, 0, 1, 1, mdata(PA, 9, 0), 1, 0, 0, "R5");
      probe(0, 0, 0, 0, 1, mdata(PA, 9, 1), 0, 0, 0, 0, 0, 0, 0, 0, "R9");
      probe(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
      idle(0, "R8");
      lookup(32'h090, PA, 0, 0, "R8");
      fill(PA, 32'h090, 32'h090, PA, 0, 0);
      lookup(32'h090, PA, 1, mdata(PA, 9, 0), "R8");
      lookup(32'h128, PB, 0, 0, "R8");
      fill(PB, 32'h128, 32'h090, PA, 1, mdata(PA, 9, 0));
      lookup(32'h054, PA, 0, 0, "R8");
      fill(PA, 32'h054, 32'h054, PA, 0, 0);
      lookup(va_of(5, 1), PA, 1, mdata(PA, 5, 1), "R4");
      lookup(va_of(5, 0), PA, 1, mdata(PA, 5, 0), "R4");
      idle(0, "R9");
      wait (expq.size() == 0);
      #4;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule